// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog peripheral on a simple register bus: an address, a write strobe, write data and combinational read data. Software selects a timeout period as a power of two. It sets the enable bit and must then keep writing a fixed key value to the restart register before a down-counter reaches zero. If the counter runs out, the block either pulses a system reset output at once or first raises an interrupt and gives software one more period to recover.

There are two period selects. One is used only when the block is first enabled. The other is used for every restart and every automatic reload after expiry. Once the enable bit is set, only the block reset clears it.

The shortest period is 2^BASE_EXP clock cycles. BASE_EXP is 16 by default, and a select value of N gives 2^(BASE_EXP+N) cycles.

Top module: `wdt_core`

## Requirements
- R1: After reset, the block is disabled. Every register reads 0, and irq_o and sys_rst_o are low. While disabled, the count stays at 0 and no expiry occurs.
- R2: Writing to address 0x0 sets the enable bit (bit 0) when the data has bit 0 set. A later write with bit 0 clear leaves the block enabled. The control register reads back {mode, enable} in bits 1:0.
- R3: In the cycle the enable bit goes from 0 to 1, the counter loads 2^(BASE_EXP+I)-1, where I is the initial select held in bits 7:4 of the range register at 0x4.
- R4: The range register at 0x4 holds the running select R in bits 3:0 and reads back in bits 7:0. Each valid restart and each expiry reloads the counter with 2^(BASE_EXP+R)-1.
- R5: Address 0x8 reads the live count. The count falls by one on each clock while the block is enabled. Writes to 0x8 have no effect.
- R6: A restart happens only when 0x00000076 is written to address 0xC while the block is enabled. Any other value, or any write while disabled, is ignored. Address 0xC reads 0.
- R7: A valid restart clears the interrupt flag (irq_o).
- R8: With the mode bit (control bit 1) at 0, an expiry drives sys_rst_o high for RST_CYC cycles, starting in the cycle after the expiry.
- R9: With the mode bit at 1, an expiry while irq_o is low sets irq_o and leaves sys_rst_o low. An expiry while irq_o is high starts the RST_CYC-cycle reset pulse.
- R10: An expiry is the clock edge at which the block is enabled and the count is 0. A valid restart at that same edge takes precedence, and no expiry occurs.
- R11: A range value of 0 followed by a restart gives the shortest period, 2^BASE_EXP cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt flag (mode 1) |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The assertions assume that the bus carries at most one write per cycle and that bus_addr and bus_wdata hold steady around each clock edge. The stimulus drives every bus change on the falling edge and returns to an idle read of the count address between writes, so these conditions hold.

The properties also assume that a restart and an enable never arrive in the same cycle, which a single-write bus guarantees. The bench aims the restart at the exact cycle the count reaches 0 by following its own model, so the precedence rule is exercised on a legal bus.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the keyed-restart watchdog.
// Assumes 4-bit byte addresses and 32-bit data on the register bus.
package wdt_pkg;
    localparam int          DATA_W     = 32;
    localparam int          ADDR_W     = 4;
    localparam int          SEL_W      = 4;
    localparam logic [3:0]  A_CTRL     = 4'h0;
    localparam logic [3:0]  A_RANGE    = 4'h4;
    localparam logic [3:0]  A_COUNT    = 4'h8;
    localparam logic [3:0]  A_RESTART  = 4'hC;
    localparam logic [31:0] RESTART_KEY = 32'h0000_0076;

    typedef struct packed {
        logic             en;
        logic             mode;
        logic [SEL_W-1:0] run_sel;
        logic [SEL_W-1:0] init_sel;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_regs.sv
// Register file: sticky enable, mode, two period selects, key check, read mux.
// Assumes one bus access per cycle; read data is combinational on the address.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CW-1:0]     cnt,
    output wdt_cfg_t          cfg,
    output logic              start,
    output logic              kick,
    output logic [DATA_W-1:0] rdata
);
    wdt_cfg_t cfg_q;

    // Decode the enable edge and a keyed restart from the current write.
    always_comb begin
        start = we && (addr == A_CTRL) && wdata[0] && !cfg_q.en;
        kick  = we && (addr == A_RESTART) && (wdata == RESTART_KEY) && cfg_q.en;
    end

    // Hold the control and range fields; enable can only be set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            if (addr == A_CTRL) begin
                cfg_q.en   <= cfg_q.en | wdata[0];
                cfg_q.mode <= wdata[1];
            end else if (addr == A_RANGE) begin
                cfg_q.run_sel  <= wdata[3:0];
                cfg_q.init_sel <= wdata[7:4];
            end
        end
    end

    // Return the addressed register; restart and unmapped addresses read 0.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {30'd0, cfg_q.mode, cfg_q.en};
            A_RANGE: rdata = {24'd0, cfg_q.init_sel, cfg_q.run_sel};
            A_COUNT: rdata = DATA_W'(cnt);
            default: rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.en |=> cfg_q.en); // R2
    AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cfg_q.en); // R3
endmodule

// File: rtl/wdt_counter.sv
// Down-counter: loads from the initial select on enable and from the
// running select on restart or expiry; flags expiry at zero.
// Assumes start and kick are never high together.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 16,
    parameter int CW       = BASE_EXP + 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             kick,
    input  logic [SEL_W-1:0] init_sel,
    input  logic [SEL_W-1:0] run_sel,
    output logic [CW-1:0]    cnt,
    output logic             expire
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] init_load;
    logic [CW-1:0] run_load;

    // Terminal value for a select: 2^(BASE_EXP+sel) - 1.
    function automatic logic [CW-1:0] load_of(input logic [SEL_W-1:0] sel);
        logic [CW-1:0] one;
        one = CW'(1);
        return (one << (BASE_EXP + int'(sel))) - one;
    endfunction

    // Precompute the two possible reload values.
    always_comb begin
        init_load = load_of(init_sel);
        run_load  = load_of(run_sel);
    end

    // Expiry happens at zero unless a restart lands in the same cycle.
    assign expire = en && (cnt_q == '0) && !kick;

    // Count down, reloading on enable, restart or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= init_load;
        else if (kick || expire) cnt_q <= run_load;
        else if (en)             cnt_q <= cnt_q - CW'(1);
    end

    assign cnt = cnt_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> cnt_q == '0); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en && !kick && cnt_q != '0 |=> cnt_q == $past(cnt_q) - CW'(1)); // R5
    AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en && cnt_q == '0 |=> cnt_q != '0); // R10
endmodule

// File: rtl/wdt_response.sv
// Expiry response: in mode 0 a reset pulse at once; in mode 1 an interrupt
// first, then a reset pulse on the next expiry. The pulse is RST_CYC long.
// Assumes kick and expire are never high together.
module wdt_response #(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic mode,
    input  logic kick,
    output logic irq,
    output logic sys_rst
);
    localparam int RC_W = $clog2(RST_CYC + 1);

    logic            irq_q;
    logic [RC_W-1:0] rc_q;
    logic            fire;

    // A reset is due on expiry in mode 0 or with the flag already set.
    assign fire = expire && (!mode || irq_q);

    // Set the interrupt on a first expiry in mode 1; a restart clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          irq_q <= 1'b0;
        else if (kick)                       irq_q <= 1'b0;
        else if (expire && mode && !irq_q)   irq_q <= 1'b1;
    end

    // Stretch the reset request to RST_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          rc_q <= '0;
        else if (fire)       rc_q <= RC_W'(RST_CYC);
        else if (rc_q != '0) rc_q <= rc_q - RC_W'(1);
    end

    assign irq     = irq_q;
    assign sys_rst = (rc_q != '0);

    AST_MODE0_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !mode |=> sys_rst); // R8
    AST_MODE1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        expire && mode && !irq_q |=> irq_q); // R9
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !irq_q); // R7
endmodule

// File: rtl/wdt_core.sv
// Top of the keyed-restart watchdog: register file, down-counter and
// expiry response. Assumes BASE_EXP <= 16 so the count fits in 32 bits.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 16,
    parameter int RST_CYC  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        sys_rst_o
);
    localparam int CW = BASE_EXP + 16;

    wdt_cfg_t      cfg;
    logic          start;
    logic          kick;
    logic          expire;
    logic [CW-1:0] cnt;

    wdt_regs #(.CW(CW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .cnt   (cnt),
        .cfg   (cfg),
        .start (start),
        .kick  (kick),
        .rdata (bus_rdata)
    );

    wdt_counter #(.BASE_EXP(BASE_EXP), .CW(CW)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.en),
        .start    (start),
        .kick     (kick),
        .init_sel (cfg.init_sel),
        .run_sel  (cfg.run_sel),
        .cnt      (cnt),
        .expire   (expire)
    );

    wdt_response #(.RST_CYC(RST_CYC)) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .mode    (cfg.mode),
        .kick    (kick),
        .irq     (irq_o),
        .sys_rst (sys_rst_o)
    );

    AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == A_RESTART && bus_wdata != RESTART_KEY && cfg.en && cnt != '0
        |=> cnt == $past(cnt) - CW'(1)); // R6
endmodule

// File: tb/wdt_core_bench.sv
// Bench with a behavioural reference model, compared after every clock.
module wdt_core_bench;
    localparam int BASE = 4;
    localparam int RCYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h8;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    always #2 clk = ~clk;

    wdt_core #(.BASE_EXP(BASE), .RST_CYC(RCYC)) u_wdt_core (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    bit     m_en, m_mode, m_irq;
    int     m_run, m_init, m_rstc;
    longint m_cnt;
    bit     k_key, k_start, k_exp;
    int     n_checks = 0, n_errs = 0, cyc = 0;
    string  cur_req = "R1";
    bit     done = 1'b0;

    function automatic longint period(int sel);
        return (longint'(1) << (BASE + sel)) - 1;
    endfunction

    function automatic logic [31:0] m_read(logic [3:0] a);
        case (a)
            4'h0: return {30'd0, m_mode, m_en};
            4'h4: return 32'((m_init << 4) | m_run);
            4'h8: return 32'(m_cnt);
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model update and comparison on every clock.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_irq = 0; m_run = 0; m_init = 0; m_rstc = 0; m_cnt = 0;
        end else begin
            k_key   = bus_we && bus_addr == 4'hC && bus_wdata == 32'h76 && m_en;
            k_start = bus_we && bus_addr == 4'h0 && bus_wdata[0] && !m_en;
            k_exp   = m_en && m_cnt == 0 && !k_key;
            if (k_exp && (!m_mode || m_irq)) m_rstc = RCYC;
            else if (m_rstc > 0) m_rstc--;
            if (k_key) m_irq = 0;
            else if (k_exp && m_mode) m_irq = 1;
            if (k_start) m_cnt = period(m_init);
            else if (k_key || k_exp) m_cnt = period(m_run);
            else if (m_en) m_cnt--;
            if (bus_we && bus_addr == 4'h0) begin
                m_en = m_en | bus_wdata[0];
                m_mode = bus_wdata[1];
            end
            if (bus_we && bus_addr == 4'h4) begin
                m_run = int'(bus_wdata[3:0]);
                m_init = int'(bus_wdata[7:4]);
            end
        end
        #1;
        if (!done) begin
            chk(cur_req, "rdata", bus_rdata, m_read(bus_addr));
            chk(cur_req, "irq_o", {31'd0, irq_o}, {31'd0, m_irq});
            chk(cur_req, "sys_rst_o", {31'd0, sys_rst_o}, {31'd0, m_rstc > 0});
        end
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_errs++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'h8; bus_wdata = '0;
    endtask

    task automatic peek(logic [3:0] a);
        bus_addr = a;
        @(negedge clk);
        bus_addr = 4'h8;
    endtask

    initial begin
        // R1: reset state and idle behaviour
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        peek(4'h0); peek(4'h4); peek(4'h8); peek(4'hC);
        idle(5);
        // R4: range readback
        cur_req = "R4";
        wr(4'h4, 32'h0000_0021);
        peek(4'h4);
        // R6: key ignored while disabled
        cur_req = "R6";
        wr(4'hC, 32'h76);
        idle(3);
        // R3: enable loads the initial select (2 -> 63)
        cur_req = "R3";
        wr(4'h0, 32'h1);
        idle(10);
        // R2: clearing enable has no effect
        cur_req = "R2";
        wr(4'h0, 32'h0);
        peek(4'h0);
        idle(3);
        // R5: count writes ignored, count keeps falling
        cur_req = "R5";
        wr(4'h8, 32'h5);
        idle(4);
        // R6: wrong key ignored, right key restarts, restart reads 0
        cur_req = "R6";
        wr(4'hC, 32'h75);
        idle(2);
        wr(4'hC, 32'h176);
        peek(4'hC);
        wr(4'hC, 32'h76);
        idle(2);
        // R8: mode 0 expiry, reset pulse, R4 reload
        cur_req = "R8";
        idle(45);
        // R10: restart exactly at zero wins
        cur_req = "R10";
        while (m_cnt != 0) @(negedge clk);
        wr(4'hC, 32'h76);
        idle(6);
        // R9: mode 1, first expiry sets irq only
        cur_req = "R9";
        wr(4'h0, 32'h3);
        while (!m_irq) @(negedge clk);
        idle(3);
        // R7: restart clears the flag
        cur_req = "R7";
        wr(4'hC, 32'h76);
        idle(3);
        // R9: two expiries lead to the reset pulse
        cur_req = "R9";
        while (m_rstc == 0) @(negedge clk);
        idle(8);
        // R11: range 0 gives the shortest period
        cur_req = "R11";
        wr(4'h4, 32'h0);
        wr(4'hC, 32'h76);
        idle(40);
        // R3: fresh reset, another initial select (3 -> 127)
        cur_req = "R3";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        wr(4'h4, 32'h30);
        wr(4'h0, 32'h3);
        idle(140);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule